// File: doc/BRIEF.md
# Glitch-Free Programmable Clock Prescaler

This block derives a host clock from a fast reference clock by dividing it by 2, 4, 8 or 16. With a 15.36 MHz reference these ratios give 7.68, 3.84, 1.92 and 0.96 MHz. A 2-bit select input picks the ratio. The output toggles only on reference edges and comes straight from a flip-flop, so it stays synchronous to the reference.

The divider never stops. A new ratio is taken over only at the end of a complete output period, which is the reference edge where the output falls. The low phase that follows that edge runs at the new ratio, so no high or low phase is ever cut short. A status output reports the ratio in force and changes on that same edge.

The asynchronous active-low reset is applied at once. Its release passes through a two-stage synchronizer before the divider starts counting.

Top module: `refclk_prescaler`

## Requirements
- R1: While reset is asserted, and while the internal synchronized reset is still low, `clk_out` is 0 and `rate_active` is 00 (divide-by-2).
- R2: The select code s gives an output period of 2^(s+1) reference cycles: 00 is ÷2, 01 is ÷4, 10 is ÷8 and 11 is ÷16.
- R3: Each high phase and each low phase lasts exactly 2^s reference cycles, where s is the ratio in force during that phase.
- R4: `rate_active` changes only on the reference edge where `clk_out` goes from 1 to 0. It then takes the value that `rate_sel` holds at that edge.
- R5: A change of `rate_sel` that is withdrawn before the next falling edge of `clk_out` has no effect on the phase lengths or on `rate_active`.
- R6: The first low phase after a ratio change lasts 2^s cycles of the new ratio s, both when the ratio gets faster and when it gets slower.
- R7: After `rst_n` is released between two reference edges, `clk_out` first goes high on the third rising reference edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Requested ratio code (00 ÷2, 01 ÷4, 10 ÷8, 11 ÷16) |
| clk_out | output | 1 | Divided clock, driven from a register |
| rate_active | output | 2 | Ratio code currently in force |

## Verification
A change of `rate_sel` has no visible result until the next falling edge of `clk_out`. At that reference edge, `rate_active` and the start of the new low phase appear together. The first rising edge after reset release comes three reference edges later, because two edges are spent in the synchronizer. The bench drives inputs on the falling reference edge and samples on the following falling edge, after each register has settled. A bench model is stepped on every rising edge and is compared with both outputs in every cycle. Directed sequences count the sampled phase lengths from the first sample of each new phase.

// File: rtl/presc_pkg.sv
package presc_pkg;
  // Level of the divided clock register
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/presc_rst_sync.sv
module presc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_ref,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nx;

  always_comb begin
    sync_nx = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_ref or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_nx;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/presc_term_decode.sv
module presc_term_decode #(
  parameter int NUM_RATES = 4,
  parameter int SEL_W     = $clog2(NUM_RATES),
  parameter int CNT_W     = (NUM_RATES > 1) ? NUM_RATES - 1 : 1
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [SEL_W-1:0] rate,
  output logic             term
);
  logic [NUM_RATES-1:0] term_vec;

  // One terminal-count comparator per ratio: half period of 2^g cycles
  for (genvar g = 0; g < NUM_RATES; g++) begin : g_cmp
    localparam logic [CNT_W-1:0] LAST = CNT_W'((1 << g) - 1);
    assign term_vec[g] = (cnt == LAST);
  end

  assign term = term_vec[rate];
endmodule

// File: rtl/presc_phase_counter.sv
module presc_phase_counter
  import presc_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             term,
  output logic [CNT_W-1:0] cnt,
  output logic             clk_out,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  phase_e           ph_q, ph_nx;

  always_comb begin
    cnt_nx = cnt_q + CNT_W'(1);
    ph_nx  = ph_q;
    if (term) begin
      cnt_nx = '0;
      ph_nx  = (ph_q == PH_HIGH) ? PH_LOW : PH_HIGH;
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= PH_LOW;
    end else begin
      cnt_q <= cnt_nx;
      ph_q  <= ph_nx;
    end
  end

  assign cnt     = cnt_q;
  assign clk_out = (ph_q == PH_HIGH);
  assign wrap    = term && (ph_q == PH_HIGH);
endmodule

// File: rtl/presc_rate_reg.sv
module presc_rate_reg #(
  parameter int SEL_W = 2
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [SEL_W-1:0] rate_req,
  output logic [SEL_W-1:0] rate_cur
);
  logic [SEL_W-1:0] rate_q, rate_nx;

  always_comb begin
    rate_nx = rate_q;
    if (load_en) rate_nx = rate_req;
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) rate_q <= '0;
    else        rate_q <= rate_nx;
  end

  assign rate_cur = rate_q;
endmodule

// File: rtl/refclk_prescaler.sv
module refclk_prescaler #(
  parameter int NUM_RATES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  output logic       clk_out,
  output logic [1:0] rate_active
);
  localparam int SEL_W = $clog2(NUM_RATES);
  localparam int CNT_W = (NUM_RATES > 1) ? NUM_RATES - 1 : 1;

  logic             rst_int_n;
  logic [CNT_W-1:0] cnt;
  logic             term;
  logic             wrap;
  logic [SEL_W-1:0] rate_cur;

  presc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_ref    (clk_ref),
    .arst_n     (rst_n),
    .rst_sync_n (rst_int_n)
  );

  presc_term_decode #(.NUM_RATES(NUM_RATES), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_term (
    .cnt  (cnt),
    .rate (rate_cur),
    .term (term)
  );

  presc_phase_counter #(.CNT_W(CNT_W)) u_phase (
    .clk_ref (clk_ref),
    .rst_n   (rst_int_n),
    .term    (term),
    .cnt     (cnt),
    .clk_out (clk_out),
    .wrap    (wrap)
  );

  // New ratio is loaded only at the end of a whole output period
  presc_rate_reg #(.SEL_W(SEL_W)) u_rate (
    .clk_ref  (clk_ref),
    .rst_n    (rst_int_n),
    .load_en  (wrap),
    .rate_req (rate_sel),
    .rate_cur (rate_cur)
  );

  assign rate_active = rate_cur;
endmodule

// File: rtl/presc_checker.sv
module presc_checker #(
  parameter int SEL_W = 2
) (
  input logic             clk_ref,
  input logic             rst_n,
  input logic             rst_int_n,
  input logic [SEL_W-1:0] rate_sel,
  input logic             clk_out,
  input logic [SEL_W-1:0] rate_active
);
  logic [7:0]       run_q;
  logic             prev_out_q;
  logic [SEL_W-1:0] prev_act_q;
  logic             seen_q;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 8'd0;
      prev_out_q <= 1'b0;
      prev_act_q <= '0;
      seen_q     <= 1'b0;
    end else begin
      prev_out_q <= clk_out;
      prev_act_q <= rate_active;
      if (clk_out != prev_out_q) begin
        run_q  <= 8'd1;
        seen_q <= 1'b1;
      end else if (run_q != 8'hFF) begin
        run_q <= run_q + 8'd1;
      end
    end
  end

  // R1: output idle and ratio at divide-by-2 while the synchronized reset is low
  assert_idle_in_reset_R1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !rst_int_n |-> (!clk_out && rate_active == '0));

  // R3: every completed phase held for 2^s cycles of the ratio then in force
  assert_phase_length_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (seen_q && clk_out != prev_out_q) |-> (run_q == 8'(1 << prev_act_q)));

  // R4: ratio status moves only together with a falling output edge
  assert_switch_on_fall_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$stable(rate_active) |-> $fell(clk_out));

  // R4: the loaded ratio is the request present at that edge
  assert_switch_value_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$stable(rate_active) |-> (rate_active == $past(rate_sel)));
endmodule

bind refclk_prescaler presc_checker #(.SEL_W(2)) u_presc_checker (
  .clk_ref     (clk_ref),
  .rst_n       (rst_n),
  .rst_int_n   (rst_int_n),
  .rate_sel    (rate_sel),
  .clk_out     (clk_out),
  .rate_active (rate_active)
);

// File: tb/refclk_prescaler_bench.sv
module refclk_prescaler_bench;
  logic       clk_ref = 1'b0;
  logic       rst_n   = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic       clk_out;
  logic [1:0] rate_active;

  int tests = 0;
  int fails = 0;
  bit track = 1'b0;

  // Model state, stepped on rising edges
  int         m_sync;
  logic       m_out;
  logic [1:0] m_act;
  int         m_cnt;
  logic       prev_out_s;
  logic [1:0] prev_act_s;

  refclk_prescaler u_refclk_prescaler (
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .rate_sel    (rate_sel),
    .clk_out     (clk_out),
    .rate_active (rate_active)
  );

  always #5 clk_ref = ~clk_ref;

  function automatic int half_len(input logic [1:0] s);
    return 1 << s;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_out = 1'b0; m_act = 2'd0; m_cnt = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else if (m_cnt == half_len(m_act) - 1) begin
      m_cnt = 0;
      if (m_out) begin m_out = 1'b0; m_act = rate_sel; end
      else m_out = 1'b1;
    end else begin
      m_cnt++;
    end
  end

  // Per-cycle comparison against the model, plus edge alignment of the status
  always @(negedge clk_ref) begin
    if (track && rst_n) begin
      chk(clk_out == m_out, "R2/R3 clk_out vs model", int'(clk_out), int'(m_out));
      chk(rate_active == m_act, "R4 rate_active vs model", int'(rate_active), int'(m_act));
      if (rate_active != prev_act_s)
        chk(prev_out_s && !clk_out, "R4 status change without falling edge",
            int'(clk_out), 0);
    end
    prev_out_s = clk_out;
    prev_act_s = rate_active;
  end

  task automatic wait_val(input logic v);
    for (int i = 0; i < 200; i++) begin
      if (clk_out == v) return;
      @(negedge clk_ref);
    end
  endtask

  task automatic run_len(output int n);
    logic v;
    v = clk_out;
    n = 1;
    @(negedge clk_ref);
    while (clk_out == v && n < 100) begin
      n++;
      @(negedge clk_ref);
    end
  endtask

  task automatic settle_rate(input logic [1:0] s);
    rate_sel = s;
    for (int i = 0; i < 100; i++) begin
      if (rate_active == s) return;
      @(negedge clk_ref);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_ref);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int hi, lo;
    void'($urandom(32'h1A2B3C));
    repeat (3) @(negedge clk_ref);
    chk(clk_out == 1'b0, "R1 clk_out in reset", int'(clk_out), 0);
    chk(rate_active == 2'd0, "R1 rate_active in reset", int'(rate_active), 0);

    // R7: two synchronizer edges, rise on the third
    rst_n = 1'b1;
    track = 1'b1;
    @(negedge clk_ref);
    chk(clk_out == 1'b0, "R7 low after edge 1", int'(clk_out), 0);
    @(negedge clk_ref);
    chk(clk_out == 1'b0, "R7 low after edge 2", int'(clk_out), 0);
    @(negedge clk_ref);
    chk(clk_out == 1'b1, "R7 high after edge 3", int'(clk_out), 1);

    // R2 / R3: period and duty for every code
    for (int s = 0; s < 4; s++) begin
      settle_rate(2'(s));
      wait_val(1'b0);
      wait_val(1'b1);
      run_len(hi);
      run_len(lo);
      chk(hi + lo == 2 * half_len(2'(s)), "R2 period", hi + lo, 2 * half_len(2'(s)));
      chk(hi == lo, "R3 equal phases", hi, lo);
    end

    // R5: short-lived request inside a high phase at divide-by-16
    settle_rate(2'd3);
    wait_val(1'b0);
    wait_val(1'b1);
    rate_sel = 2'd0;
    repeat (3) @(negedge clk_ref);
    rate_sel = 2'd3;
    wait_val(1'b0);
    chk(rate_active == 2'd3, "R5 withdrawn request ignored", int'(rate_active), 3);
    run_len(lo);
    chk(lo == 8, "R5 low phase unchanged", lo, 8);

    // R6: slow to fast, then fast to slow
    wait_val(1'b1);
    rate_sel = 2'd0;
    wait_val(1'b0);
    chk(rate_active == 2'd0, "R4 switch to fast at fall", int'(rate_active), 0);
    run_len(lo);
    chk(lo == 1, "R6 first low after speed-up", lo, 1);
    rate_sel = 2'd3;
    wait_val(1'b0);
    chk(rate_active == 2'd3, "R4 switch to slow at fall", int'(rate_active), 3);
    run_len(lo);
    chk(lo == 8, "R6 first low after slow-down", lo, 8);

    // Random select changes, checked against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk_ref);
      if ($urandom % 12 == 0) rate_sel = 2'($urandom % 4);
    end

    // R1: asynchronous reset mid-run
    wait_val(1'b1);
    rst_n = 1'b0;
    #1;
    chk(clk_out == 1'b0, "R1 async reset clears output", int'(clk_out), 0);
    chk(rate_active == 2'd0, "R1 async reset clears ratio", int'(rate_active), 0);
    track = 1'b0;
    repeat (2) @(negedge clk_ref);
    finish_run();
  end
endmodule